// File: doc/BRIEF.md
# Transactional Cache Set Tracker

This block follows the read set and the write set of one hardware transaction inside the tag array of a small set-associative data cache. Each cache line carries two marks: one for a transactional read and one for a transactional write. Local hits that are flagged as transactional set these marks while a transaction is open. Remote stores and invalidations are checked against the marks. A conflict is either held off with a negative acknowledgement, for a limited number of times per transaction, or it aborts the transaction.

A read-marked line that leaves the cache is still tracked. Its whole set is flagged, and any later remote store that indexes that set aborts the transaction, even when the tag does not match. Written lines must stay resident and are limited in number. Losing one, or going past the limit, aborts the transaction for lack of capacity.

On commit, every mark and set flag clears in one cycle and written lines become plain valid lines. On abort, the written lines are invalidated so that later reads miss and refetch. Read-only lines stay valid. Line fills and evictions come in through one line-operation port. Every output is registered and appears one cycle after the inputs that caused it.

Top module: `txset_tracker`

## Requirements
- R1: After reset, no line is valid, `tx_active`, `hit_o`, `abort_o` and `nack_o` are 0, and an access misses.
- R2: `hit_o` rises one cycle after an access exactly when a valid line in set `acc_idx` holds `acc_tag`. A line operation with `lop_fill`=1 installs `lop_tag` in way `lop_way`. With `lop_fill`=0 it removes the line.
- R3: `tx_begin` opens a transaction, and `tx_active` is 1 in the next cycle. While the transaction is open, a transactional store hit marks the line written, and the line stays readable (it hits). After commit it is still valid.
- R4: While active, a remote store or invalidate (`snp_store`=1 or 0) that hits a read- or write-marked line with no NACK credit left pulses `abort_o` with `abort_code` 0 (conflict). The snooped line is invalidated.
- R5: Each transaction holds NACK_MAX credits (default 2). A conflicting snoop that finds a credit pulses `nack_o` instead of aborting, and keeps the line valid.
- R6: Removing a read-marked line while active flags its set. A later remote store to that set with any tag gives `abort_code` 2. A remote invalidate to a flagged set does not abort.
- R7: Removing a write-marked line while active aborts with `abort_code` 1 (capacity).
- R8: At most WR_CAP distinct lines (default 64) may be write-marked. A transactional store that would mark line WR_CAP+1 aborts with code 1, and repeated stores to a line that is already marked do not count.
- R9: `tx_abort_req` while active aborts with `abort_code` 3 (explicit).
- R10: On any abort, the write-marked lines become invalid, read-only lines stay valid, all marks clear, and `tx_active` drops.
- R11: Commit clears all marks and set flags in the same cycle, so that later snoops to former read lines or flagged sets do not abort.
- R12: When several events fall in one cycle, the abort cause is chosen in the order conflict, then set flag, then capacity, then explicit. An abort takes precedence over a commit in the same cycle, and no NACK is given in a cycle that aborts.
- R13: A snoop that hits an unmarked line invalidates it with no NACK and no abort. Non-transactional accesses, and any access while no transaction is open, mark nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_begin | input | 1 | Open a transaction (ignored while one is open) |
| tx_commit | input | 1 | Commit the open transaction |
| tx_abort_req | input | 1 | Explicit abort request |
| acc_vld | input | 1 | Local access valid |
| acc_wr | input | 1 | Local access is a store |
| acc_tx | input | 1 | Local access is transactional |
| acc_idx | input | IDX_W | Local access set index |
| acc_tag | input | TAG_W | Local access tag |
| lop_vld | input | 1 | Line operation valid |
| lop_fill | input | 1 | 1 = install tag, 0 = remove line |
| lop_idx | input | IDX_W | Line operation set |
| lop_way | input | WAY_W | Line operation way |
| lop_tag | input | TAG_W | Tag to install |
| snp_vld | input | 1 | Remote snoop valid |
| snp_store | input | 1 | 1 = remote store, 0 = remote invalidate |
| snp_idx | input | IDX_W | Snoop set index |
| snp_tag | input | TAG_W | Snoop tag |
| hit_o | output | 1 | Registered access hit |
| tx_active | output | 1 | Transaction open |
| abort_o | output | 1 | One-cycle abort pulse |
| abort_code | output | 2 | 0 conflict, 1 capacity, 2 flagged-set store, 3 explicit |
| nack_o | output | 1 | One-cycle negative acknowledgement to the snoop |

## Verification
A snoop decision can land in the same cycle as a commit or an explicit abort request. The bench forces these collisions by asserting a conflicting snoop together with `tx_commit`, first after the credits are spent and then while a credit remains. It also pairs a remote store to a flagged set with `tx_abort_req`. Each outcome is judged from the pulse and code one cycle later against R12: a conflict abort beats the commit, a NACK lets the commit through, and the flagged-set code beats the explicit one.

// File: rtl/txt_pkg.sv
package txt_pkg;
  typedef enum logic [1:0] {
    ABT_CONFLICT = 2'd0,
    ABT_CAPACITY = 2'd1,
    ABT_OVFSET   = 2'd2,
    ABT_EXPLICIT = 2'd3
  } abort_e;
endpackage

// File: rtl/txt_set_match.sv
module txt_set_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 10,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS*TAG_W-1:0] tags,
  input  logic [WAYS-1:0]       vlds,
  input  logic [TAG_W-1:0]      tag,
  output logic                  hit,
  output logic [WAY_W-1:0]      way
);
  logic [WAYS-1:0] eq;

  for (genvar gw = 0; gw < WAYS; gw++) begin : g_cmp
    assign eq[gw] = vlds[gw] && (tags[gw*TAG_W +: TAG_W] == tag);
  end

  // lowest matching way wins
  always_comb begin
    way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (eq[w]) way = WAY_W'(w);
    end
  end

  assign hit = |eq;
endmodule

// File: rtl/txt_credit.sv
module txt_credit #(
  parameter int NACK_MAX = 2,
  localparam int CR_W = (NACK_MAX < 1) ? 1 : $clog2(NACK_MAX + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic take,
  output logic has
);
  logic [CR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CR_W'(NACK_MAX);
    end else if (take && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign has = (cnt_q != '0);
endmodule

// File: rtl/txset_tracker.sv
module txset_tracker
  import txt_pkg::*;
#(
  parameter int SETS     = 32,
  parameter int WAYS     = 4,
  parameter int TAG_W    = 10,
  parameter int WR_CAP   = 64,
  parameter int NACK_MAX = 2,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_begin,
  input  logic             tx_commit,
  input  logic             tx_abort_req,
  input  logic             acc_vld,
  input  logic             acc_wr,
  input  logic             acc_tx,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic [TAG_W-1:0] acc_tag,
  input  logic             lop_vld,
  input  logic             lop_fill,
  input  logic [IDX_W-1:0] lop_idx,
  input  logic [WAY_W-1:0] lop_way,
  input  logic [TAG_W-1:0] lop_tag,
  input  logic             snp_vld,
  input  logic             snp_store,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic [TAG_W-1:0] snp_tag,
  output logic             hit_o,
  output logic             tx_active,
  output logic             abort_o,
  output logic [1:0]       abort_code,
  output logic             nack_o
);
  localparam int LI_W  = IDX_W + WAY_W;
  localparam int LINES = SETS * WAYS;
  localparam int CNT_W = $clog2(WR_CAP + 1);

  // tag store: written only by fills, no reset (RAM friendly)
  logic [TAG_W-1:0] tag_mem [LINES];
  // marks and valid bits in flops for single-cycle flash clear
  logic [LINES-1:0] vld_q, rd_q, wr_q, vld_n, rd_n, wr_n;
  logic [SETS-1:0]  ovf_q, ovf_n;
  logic             act_q;
  logic [CNT_W-1:0] wcnt_q;

  logic [WAYS*TAG_W-1:0] acc_tags, snp_tags;
  logic [WAYS-1:0]       acc_vlds, snp_vlds;
  logic                  a_hit, s_hit;
  logic [WAY_W-1:0]      a_way, s_way;

  for (genvar gw = 0; gw < WAYS; gw++) begin : g_gather
    assign acc_tags[gw*TAG_W +: TAG_W] = tag_mem[{acc_idx, WAY_W'(gw)}];
    assign acc_vlds[gw]                = vld_q[{acc_idx, WAY_W'(gw)}];
    assign snp_tags[gw*TAG_W +: TAG_W] = tag_mem[{snp_idx, WAY_W'(gw)}];
    assign snp_vlds[gw]                = vld_q[{snp_idx, WAY_W'(gw)}];
  end

  txt_set_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_acc_match (
    .tags(acc_tags), .vlds(acc_vlds), .tag(acc_tag), .hit(a_hit), .way(a_way)
  );

  txt_set_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_snp_match (
    .tags(snp_tags), .vlds(snp_vlds), .tag(snp_tag), .hit(s_hit), .way(s_way)
  );

  logic [LI_W-1:0] aline, sline, lline;
  assign aline = {acc_idx, a_way};
  assign sline = {snp_idx, s_way};
  assign lline = {lop_idx, lop_way};

  logic a_hit_v, a_mark, a_new_wr, cap_acc;
  logic s_hit_v, s_tx, credit_ok, s_nack;
  logic l_old, l_rdspill;
  logic c_conf, c_ovf, c_cap, c_exp, any_ab, do_commit, do_begin, nack_fire;
  abort_e code_n;

  assign a_hit_v   = acc_vld && a_hit;
  assign a_mark    = act_q && a_hit_v && acc_tx;
  assign a_new_wr  = a_mark && acc_wr && !wr_q[aline];
  assign cap_acc   = a_new_wr && (wcnt_q == CNT_W'(WR_CAP));

  assign s_hit_v   = snp_vld && s_hit;
  assign s_tx      = act_q && s_hit_v && (rd_q[sline] || wr_q[sline]);
  assign s_nack    = s_tx && credit_ok;

  assign l_old     = lop_vld && vld_q[lline];
  assign l_rdspill = act_q && l_old && rd_q[lline];

  assign c_conf    = s_tx && !credit_ok;
  assign c_ovf     = act_q && snp_vld && snp_store && ovf_q[snp_idx] && !s_tx;
  assign c_cap     = cap_acc || (act_q && l_old && wr_q[lline]);
  assign c_exp     = act_q && tx_abort_req;
  assign any_ab    = c_conf || c_ovf || c_cap || c_exp;
  assign do_commit = act_q && tx_commit && !any_ab;
  assign do_begin  = !act_q && tx_begin;
  assign nack_fire = s_nack && !any_ab;

  always_comb begin
    if (c_conf)     code_n = ABT_CONFLICT;
    else if (c_ovf) code_n = ABT_OVFSET;
    else if (c_cap) code_n = ABT_CAPACITY;
    else            code_n = ABT_EXPLICIT;
  end

  txt_credit #(.NACK_MAX(NACK_MAX)) u_credit (
    .clk(clk), .rst(rst), .load(do_begin), .take(nack_fire), .has(credit_ok)
  );

  always_comb begin
    vld_n = vld_q;
    rd_n  = rd_q;
    wr_n  = wr_q;
    ovf_n = ovf_q;
    if (a_mark && !cap_acc) begin
      if (acc_wr) wr_n[aline] = 1'b1;
      else        rd_n[aline] = 1'b1;
    end
    if (s_hit_v && !nack_fire) begin
      vld_n[sline] = 1'b0;
      rd_n[sline]  = 1'b0;
      wr_n[sline]  = 1'b0;
    end
    if (lop_vld) begin
      vld_n[lline] = lop_fill;
      rd_n[lline]  = 1'b0;
      wr_n[lline]  = 1'b0;
    end
    if (l_rdspill) ovf_n[lop_idx] = 1'b1;
    if (any_ab) begin
      vld_n = vld_n & ~wr_n;
      rd_n  = '0;
      wr_n  = '0;
      ovf_n = '0;
    end else if (do_commit) begin
      rd_n  = '0;
      wr_n  = '0;
      ovf_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (lop_vld && lop_fill) tag_mem[lline] <= lop_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q      <= '0;
      rd_q       <= '0;
      wr_q       <= '0;
      ovf_q      <= '0;
      act_q      <= 1'b0;
      wcnt_q     <= '0;
      hit_o      <= 1'b0;
      abort_o    <= 1'b0;
      abort_code <= 2'd0;
      nack_o     <= 1'b0;
    end else begin
      vld_q      <= vld_n;
      rd_q       <= rd_n;
      wr_q       <= wr_n;
      ovf_q      <= ovf_n;
      hit_o      <= a_hit_v;
      abort_o    <= any_ab;
      abort_code <= any_ab ? code_n : 2'd0;
      nack_o     <= nack_fire;
      if (do_begin)                act_q <= 1'b1;
      else if (any_ab || do_commit) act_q <= 1'b0;
      if (do_begin || any_ab || do_commit) wcnt_q <= '0;
      else if (a_new_wr)                   wcnt_q <= wcnt_q + 1'b1;
    end
  end

  assign tx_active = act_q;
endmodule

// File: rtl/txset_tracker_chk.sv
module txset_tracker_chk (
  input logic       clk,
  input logic       rst,
  input logic       tx_begin,
  input logic       tx_abort_req,
  input logic       snp_vld,
  input logic       tx_active,
  input logic       abort_o,
  input logic [1:0] abort_code,
  input logic       nack_o
);
  AST_BEGIN_OPENS: assert property (@(posedge clk) disable iff (rst)
    (!tx_active && tx_begin) |=> tx_active); // R3
  AST_ABORT_CLOSES: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> !tx_active); // R10
  AST_ABORT_FROM_OPEN: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> $past(tx_active)); // R10
  AST_EXPLICIT_ABORTS: assert property (@(posedge clk) disable iff (rst)
    (tx_active && tx_abort_req) |=> abort_o); // R9
  AST_EXPLICIT_CODE_SRC: assert property (@(posedge clk) disable iff (rst)
    (abort_o && abort_code == 2'd3) |-> $past(tx_abort_req)); // R9
  AST_NACK_FROM_SNOOP: assert property (@(posedge clk) disable iff (rst)
    nack_o |-> $past(snp_vld)); // R5
  AST_NACK_NOT_ABORT: assert property (@(posedge clk) disable iff (rst)
    nack_o |-> !abort_o); // R12
endmodule

bind txset_tracker txset_tracker_chk u_chk (
  .clk(clk), .rst(rst), .tx_begin(tx_begin), .tx_abort_req(tx_abort_req),
  .snp_vld(snp_vld), .tx_active(tx_active), .abort_o(abort_o),
  .abort_code(abort_code), .nack_o(nack_o)
);

// File: tb/txset_tracker_bench.sv
`timescale 1ns/1ps
module txset_tracker_bench;
  localparam int IDX_W = 5;
  localparam int WAY_W = 2;
  localparam int TAG_W = 10;

  logic clk = 1'b0;
  logic rst;
  logic tx_begin, tx_commit, tx_abort_req;
  logic acc_vld, acc_wr, acc_tx;
  logic [IDX_W-1:0] acc_idx;
  logic [TAG_W-1:0] acc_tag;
  logic lop_vld, lop_fill;
  logic [IDX_W-1:0] lop_idx;
  logic [WAY_W-1:0] lop_way;
  logic [TAG_W-1:0] lop_tag;
  logic snp_vld, snp_store;
  logic [IDX_W-1:0] snp_idx;
  logic [TAG_W-1:0] snp_tag;
  logic hit_o, tx_active, abort_o, nack_o;
  logic [1:0] abort_code;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  txset_tracker u_txset_tracker (
    .clk(clk), .rst(rst), .tx_begin(tx_begin), .tx_commit(tx_commit),
    .tx_abort_req(tx_abort_req), .acc_vld(acc_vld), .acc_wr(acc_wr),
    .acc_tx(acc_tx), .acc_idx(acc_idx), .acc_tag(acc_tag),
    .lop_vld(lop_vld), .lop_fill(lop_fill), .lop_idx(lop_idx),
    .lop_way(lop_way), .lop_tag(lop_tag), .snp_vld(snp_vld),
    .snp_store(snp_store), .snp_idx(snp_idx), .snp_tag(snp_tag),
    .hit_o(hit_o), .tx_active(tx_active), .abort_o(abort_o),
    .abort_code(abort_code), .nack_o(nack_o)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic chkab(string req, int ab, int code);
    chk(req, abort_o, ab);
    if (ab != 0) chk(req, abort_code, code);
  endtask

  task automatic idle();
    tx_begin = 0; tx_commit = 0; tx_abort_req = 0;
    acc_vld = 0; acc_wr = 0; acc_tx = 0; acc_idx = '0; acc_tag = '0;
    lop_vld = 0; lop_fill = 0; lop_idx = '0; lop_way = '0; lop_tag = '0;
    snp_vld = 0; snp_store = 0; snp_idx = '0; snp_tag = '0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic fill(int i, int w, int t);
    lop_vld = 1; lop_fill = 1; lop_idx = IDX_W'(i); lop_way = WAY_W'(w);
    lop_tag = TAG_W'(t); tick(); idle();
  endtask

  task automatic evict(int i, int w);
    lop_vld = 1; lop_fill = 0; lop_idx = IDX_W'(i); lop_way = WAY_W'(w);
    tick(); idle();
  endtask

  task automatic acc(bit wr, bit tx, int i, int t);
    acc_vld = 1; acc_wr = wr; acc_tx = tx; acc_idx = IDX_W'(i);
    acc_tag = TAG_W'(t); tick(); idle();
  endtask

  task automatic snp(bit st, int i, int t);
    snp_vld = 1; snp_store = st; snp_idx = IDX_W'(i); snp_tag = TAG_W'(t);
    tick(); idle();
  endtask

  task automatic beg();
    tx_begin = 1; tick(); idle();
  endtask

  task automatic cmt();
    tx_commit = 1; tick(); idle();
  endtask

  // bench model of tag/valid state for the random phase (sets 0..2)
  bit mv[3][4];
  int mt[3][4];

  function automatic bit mhit(int i, int t);
    for (int w = 0; w < 4; w++) if (mv[i][w] && mt[i][w] == t) return 1;
    return 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    repeat (3) tick();
    // R1 reset state
    chk("R1 tx_active", tx_active, 0);
    chk("R1 abort", abort_o, 0);
    chk("R1 nack", nack_o, 0);
    rst = 0;
    tick();
    acc(0, 0, 0, 0);
    chk("R1 miss after reset", hit_o, 0);

    // random phase: no transaction, fills/evicts/accesses/snoops (R2, R13)
    void'($urandom(32'd4242));
    for (int i = 0; i < 3; i++) for (int w = 0; w < 4; w++) mv[i][w] = 0;
    for (int n = 0; n < 400; n++) begin
      int op = $urandom % 4;
      int si = $urandom % 3;
      int sw = $urandom % 4;
      int st = sw + 4 * ($urandom % 4);
      case (op)
        0: begin fill(si, sw, st); mv[si][sw] = 1; mt[si][sw] = st; end
        1: begin evict(si, sw); mv[si][sw] = 0; end
        2: begin
          bit e = mhit(si, st);
          acc(0, $urandom % 2, si, st);
          chk("R2 random hit", hit_o, e);
        end
        default: begin
          snp($urandom % 2, si, st);
          chk("R13 random snoop quiet", abort_o | nack_o, 0);
          for (int w = 0; w < 4; w++) if (mv[si][w] && mt[si][w] == st) mv[si][w] = 0;
        end
      endcase
    end

    // R2 directed
    fill(3, 0, 'h11);
    acc(0, 0, 3, 'h11); chk("R2 hit after fill", hit_o, 1);
    acc(0, 0, 3, 'h12); chk("R2 other tag miss", hit_o, 0);
    evict(3, 0);
    acc(0, 0, 3, 'h11); chk("R2 miss after remove", hit_o, 0);

    // R13 snoop on plain line invalidates quietly
    fill(4, 1, 'h20);
    snp(1, 4, 'h20); chk("R13 no nack", nack_o, 0); chkab("R13 no abort", 0, 0);
    acc(0, 0, 4, 'h20); chk("R13 plain line invalidated", hit_o, 0);
    // R13 non-transactional access during a transaction marks nothing
    fill(20, 0, 'h2A);
    beg();
    acc(0, 0, 20, 'h2A); chk("R13 plain access hit", hit_o, 1);
    snp(1, 20, 'h2A); chk("R13 unmarked no nack", nack_o, 0); chkab("R13 unmarked no abort", 0, 0);
    chk("R13 still active", tx_active, 1);
    cmt();

    // R3 own write readable, survives commit; R11 marks cleared
    fill(5, 0, 'h30);
    beg(); chk("R3 active", tx_active, 1);
    acc(1, 1, 5, 'h30); chk("R3 store hit", hit_o, 1); chkab("R3 no abort", 0, 0);
    acc(0, 1, 5, 'h30); chk("R3 read own write", hit_o, 1);
    cmt(); chk("R3 commit closes", tx_active, 0); chkab("R3 commit no abort", 0, 0);
    acc(0, 0, 5, 'h30); chk("R3 line kept after commit", hit_o, 1);
    snp(1, 5, 'h30); chkab("R11 committed line no abort", 0, 0);

    // R5 credits then R4 conflict
    fill(7, 0, 'h40);
    beg();
    acc(0, 1, 7, 'h40);
    snp(0, 7, 'h40); chk("R5 nack 1", nack_o, 1); chkab("R5 no abort 1", 0, 0);
    snp(0, 7, 'h40); chk("R5 nack 2", nack_o, 1); chkab("R5 no abort 2", 0, 0);
    acc(0, 0, 7, 'h40); chk("R5 line kept", hit_o, 1);
    snp(0, 7, 'h40); chk("R4 no nack", nack_o, 0); chkab("R4 conflict", 1, 0);
    chk("R4 closes", tx_active, 0);
    acc(0, 0, 7, 'h40); chk("R4 snooped line gone", hit_o, 0);

    // R9 explicit, R10 written lost / read kept
    fill(8, 0, 'h50); fill(8, 1, 'h51);
    beg();
    acc(1, 1, 8, 'h50); acc(0, 1, 8, 'h51);
    tx_abort_req = 1; tick(); idle();
    chkab("R9 explicit", 1, 3);
    acc(0, 0, 8, 'h50); chk("R10 written line invalid", hit_o, 0);
    acc(0, 0, 8, 'h51); chk("R10 read line kept", hit_o, 1);
    beg();
    snp(1, 8, 'h51); chkab("R10 marks cleared", 0, 0);
    cmt();

    // R6 overflow set
    fill(9, 0, 'h60);
    beg();
    acc(0, 1, 9, 'h60);
    evict(9, 0); chkab("R6 read eviction no abort", 0, 0);
    snp(0, 9, 'h77); chkab("R6 invalidate ignored", 0, 0);
    snp(1, 9, 'h77); chkab("R6 flagged set store", 1, 2);

    // R11 commit clears set flag
    fill(10, 0, 'h70);
    beg(); acc(0, 1, 10, 'h70); evict(10, 0); cmt();
    beg(); snp(1, 10, 'h99); chkab("R11 flag cleared", 0, 0); cmt();

    // R7 written line evicted
    fill(11, 0, 'h80);
    beg(); acc(1, 1, 11, 'h80);
    evict(11, 0); chkab("R7 written eviction", 1, 1);

    // R8 write capacity
    for (int n = 0; n < 65; n++) fill(12 + n / 4, n % 4, 'h100 + n);
    beg();
    for (int n = 0; n < 64; n++) begin
      acc(1, 1, 12 + n / 4, 'h100 + n);
      chkab("R8 within capacity", 0, 0);
    end
    acc(1, 1, 12, 'h100); chkab("R8 repeat store not counted", 0, 0);
    acc(1, 1, 28, 'h140); chkab("R8 over capacity", 1, 1);
    acc(0, 0, 12, 'h100); chk("R10 capacity abort drops writes", hit_o, 0);

    // R12 conflict beats commit
    fill(30, 0, 'hA0);
    beg(); acc(0, 1, 30, 'hA0);
    snp(0, 30, 'hA0); snp(0, 30, 'hA0);
    snp_vld = 1; snp_store = 0; snp_idx = 30; snp_tag = 'hA0; tx_commit = 1;
    tick(); idle();
    chkab("R12 conflict over commit", 1, 0); chk("R12 nack suppressed", nack_o, 0);
    // R12 flagged set beats explicit
    fill(31, 0, 'hB0);
    beg(); acc(0, 1, 31, 'hB0); evict(31, 0);
    snp_vld = 1; snp_store = 1; snp_idx = 31; snp_tag = 'h5; tx_abort_req = 1;
    tick(); idle();
    chkab("R12 flag over explicit", 1, 2);
    // R12 nack with commit lets commit through
    fill(29, 1, 'hC0);
    beg(); acc(0, 1, 29, 'hC0);
    snp_vld = 1; snp_store = 0; snp_idx = 29; snp_tag = 'hC0; tx_commit = 1;
    tick(); idle();
    chk("R12 nack with commit", nack_o, 1); chkab("R12 commit no abort", 0, 0);
    chk("R12 committed", tx_active, 0);

    summary();
    $finish;
  end
endmodule